// File: doc/BRIEF.md
# Passive Serial Configuration Streamer

This block feeds a bitstream, held as words in a small on-chip queue, into the passive serial configuration port of a target FPGA. It produces the serial configuration clock, drives the single data line, runs the program/init handshake with the target and reports whether the target finished configuring or the load failed. Host-side logic writes the queue entries and a few control fields. Each entry carries a 32-bit data word, a 2-bit byte count and an end-of-bitstream marker.

A load goes like this. The host issues a soft reset, writes the divider and bit-order fields, and queues entries. It then issues a start. The streamer pulls the program line low and waits for the target to answer on its init line. Once init is high again it clocks out the queued data. After the marked last entry it keeps the clock running until the target raises done. If done never arrives within a bounded number of clocks, the load is flagged as failed. A target that pulls init low while clocks are being sent also fails the load.

Top module: `ps_cfg_streamer`

## Requirements
- R1: After the asynchronous reset `prog_b_o` is 1, `cclk_o` is 0, `stat_done`, `stat_error` and `stat_busy` are 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: `fifo_full` is 1 when FIFO_DEPTH entries are queued and `fifo_empty` is 1 when none are. A push while full is dropped and never reaches the data line.
- R3: While clocking, one `cclk_o` period lasts 2*(div+1) system cycles, where div is the divider field. The divider resets to 1, giving 4 cycles.
- R4: A start pulse drives `prog_b_o` low for at least PROG_CYC cycles. No `cclk_o` rising edge occurs until `init_b_i` has been seen low and then high again.
- R5: With bit-order field 1, the most significant valid byte goes first and each byte is sent bit 7 first. `din_o` changes only while `cclk_o` is low, and it never changes while `cclk_o` is high.
- R6: With bit-order field 0, the exact reverse order is used: byte 0 goes first and each byte is sent bit 0 first.
- R7: An entry with size field s (0..3) sends 8*(s+1) bits taken from data bits [8*(s+1)-1:0]. The upper bits are not sent.
- R8: After the last bit of an entry with the last flag set, `cclk_o` keeps toggling with `din_o` at 1. When `done_i` goes high, `stat_done` becomes 1 and `cclk_o` stops low.
- R9: If `done_i` stays low for TRAIL_MAX trailing rising edges, `stat_error` becomes 1 and no more rising edges follow.
- R10: `init_b_i` going low while data or trailing clocks are being sent sets `stat_error` and stops `cclk_o`.
- R11: A start pulse is ignored unless the streamer is idle. A soft reset pulse returns it to idle, clears `stat_done` and `stat_error`, and empties the queue.
- R12: If `init_b_i` does not rise within INIT_TMO cycles of the handshake stage, `stat_error` becomes 1 and no clock is sent.
- R13: When the queue runs empty before a last-flagged entry, `cclk_o` halts low and resumes once a new entry is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for divider and bit-order fields |
| cfg_msbf | input | 1 | Bit-order field: 1 = MSB first, 0 = LSB first |
| cfg_div | input | DIV_W | Clock divider field |
| cmd_srst | input | 1 | Soft reset pulse |
| cmd_start | input | 1 | Start pulse |
| fifo_we | input | 1 | Push strobe for one queue entry |
| fifo_size | input | 2 | Byte count minus one of the entry |
| fifo_last | input | 1 | Entry ends the bitstream |
| fifo_data | input | 32 | Entry data word |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| prog_b_o | output | 1 | Program line to target, active low |
| init_b_i | input | 1 | Init line from target |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Serial data |
| done_i | input | 1 | Done line from target |
| stat_done | output | 1 | Configuration finished |
| stat_error | output | 1 | Configuration failed |
| stat_busy | output | 1 | Load in progress |

## Verification
Target lines pass through a two-stage synchronizer and then into the state register. A change on `init_b_i` or `done_i` therefore shows up on the status outputs three system cycles later. The bench waits for each such result with a bounded poll and never samples one fixed cycle. Serial data is captured by a target model on every `cclk_o` rising edge. The model samples at the falling system-clock edge and records the cycle spacing of the edges, so bit order and the 2*(div+1) period are checked against the captured trace and not against edge timing. Cases that assert something never happens (dropped pushes, a halted clock, an ignored start) are checked after a settling window of 20 to 30 cycles.

// File: rtl/pscs_pkg.sv
package pscs_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WINIT,
    ST_SHIFT,
    ST_TRAIL,
    ST_OK,
    ST_FAIL
  } st_e;

  typedef struct packed {
    logic              last;
    logic [SIZE_W-1:0] size;
    logic [WORD_W-1:0] data;
  } entry_t;

endpackage

// File: rtl/pscs_sync.sv
module pscs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= {STAGES{RST_VAL}};
    end else begin
      ff_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/pscs_fifo.sv
module pscs_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr && !full && !flush;
  assign rd_ok = rd && !empty && !flush;
  assign rdata = mem[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wp_d = bump(wp_q);
      if (rd_ok) rp_d = bump(rp_q);
      if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/pscs_clkgen.sv
module pscs_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q >= div);
  assign tick   = run && !hold && at_end;

  always_comb begin
    if (!run || hold) cnt_d = '0;
    else if (at_end)  cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pscs_engine.sv
module pscs_engine
  import pscs_pkg::*;
#(
  parameter int PROG_CYC  = 8,
  parameter int INIT_TMO  = 4096,
  parameter int TRAIL_MAX = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   srst,
  input  logic   start,
  input  logic   msbf,
  input  logic   tick,
  input  logic   init_s,
  input  logic   done_s,
  input  logic   fifo_empty,
  input  entry_t entry,
  output logic   pop,
  output logic   run,
  output logic   hold,
  output logic   prog_b,
  output logic   cclk,
  output logic   din,
  output logic   st_done,
  output logic   st_err,
  output logic   busy
);

  localparam int TMO_W = $clog2(INIT_TMO + 1);
  localparam int TR_W  = $clog2(TRAIL_MAX + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);

  st_e               st_q, st_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [TR_W-1:0]   tr_q, tr_d;
  logic              cclk_q, cclk_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bits_q, bits_d;
  logic              have_q, have_d;
  logic              lastw_q, lastw_d;
  logic              msbf_q, msbf_d;

  logic [SIZE_W-1:0] pad;
  logic [WORD_W-1:0] ld_word;
  logic [2:0]        nbytes;

  // Left-align the valid bytes for MSB-first, keep them low for LSB-first.
  assign pad     = SIZE_W'(3) - entry.size;
  assign ld_word = msbf_q ? (entry.data << {pad, 3'b000}) : entry.data;
  assign nbytes  = {1'b0, entry.size} + 3'd1;

  always_comb begin
    st_d    = st_q;
    tmo_d   = tmo_q;
    tr_d    = tr_q;
    cclk_d  = cclk_q;
    sh_d    = sh_q;
    bits_d  = bits_q;
    have_d  = have_q;
    lastw_d = lastw_q;
    msbf_d  = msbf_q;
    pop     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        cclk_d = 1'b0;
        if (start) begin
          st_d   = ST_PROG;
          tmo_d  = '0;
          msbf_d = msbf;
        end
      end
      ST_PROG: begin
        tmo_d = tmo_q + 1'b1;
        if (tmo_q >= TMO_W'(PROG_CYC - 1) && !init_s) begin
          st_d  = ST_WINIT;
          tmo_d = '0;
        end else if (tmo_q == TMO_W'(INIT_TMO)) begin
          st_d = ST_FAIL;
        end
      end
      ST_WINIT: begin
        tmo_d = tmo_q + 1'b1;
        if (init_s) begin
          st_d   = ST_SHIFT;
          have_d = 1'b0;
          cclk_d = 1'b0;
        end else if (tmo_q == TMO_W'(INIT_TMO)) begin
          st_d = ST_FAIL;
        end
      end
      ST_SHIFT: begin
        if (!init_s) begin
          st_d   = ST_FAIL;
          cclk_d = 1'b0;
        end else if (have_q && tick) begin
          if (!cclk_q) begin
            cclk_d = 1'b1;
          end else begin
            cclk_d = 1'b0;
            sh_d   = msbf_q ? (sh_q << 1) : (sh_q >> 1);
            bits_d = bits_q - 1'b1;
            if (bits_q == BIT_W'(1)) begin
              have_d = 1'b0;
              if (lastw_q) begin
                st_d = ST_TRAIL;
                tr_d = '0;
              end
            end
          end
        end else if (!have_q && !fifo_empty) begin
          pop     = 1'b1;
          sh_d    = ld_word;
          bits_d  = BIT_W'({nbytes, 3'b000});
          have_d  = 1'b1;
          lastw_d = entry.last;
        end
      end
      ST_TRAIL: begin
        if (!init_s) begin
          st_d   = ST_FAIL;
          cclk_d = 1'b0;
        end else if (done_s) begin
          st_d   = ST_OK;
          cclk_d = 1'b0;
        end else if (tr_q == TR_W'(TRAIL_MAX)) begin
          st_d   = ST_FAIL;
          cclk_d = 1'b0;
        end else if (tick) begin
          cclk_d = !cclk_q;
          if (!cclk_q) tr_d = tr_q + 1'b1;
        end
      end
      ST_OK, ST_FAIL: begin
        cclk_d = 1'b0;
      end
      default: begin
        st_d   = ST_IDLE;
        cclk_d = 1'b0;
      end
    endcase

    if (srst) begin
      st_d   = ST_IDLE;
      cclk_d = 1'b0;
      have_d = 1'b0;
      pop    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmo_q   <= '0;
      tr_q    <= '0;
      cclk_q  <= 1'b0;
      sh_q    <= '0;
      bits_q  <= '0;
      have_q  <= 1'b0;
      lastw_q <= 1'b0;
      msbf_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      tmo_q   <= tmo_d;
      tr_q    <= tr_d;
      cclk_q  <= cclk_d;
      sh_q    <= sh_d;
      bits_q  <= bits_d;
      have_q  <= have_d;
      lastw_q <= lastw_d;
      msbf_q  <= msbf_d;
    end
  end

  assign run     = (st_q == ST_SHIFT) || (st_q == ST_TRAIL);
  assign hold    = (st_q == ST_SHIFT) && !have_q;
  assign prog_b  = (st_q != ST_PROG);
  assign cclk    = cclk_q;
  assign din     = have_q ? (msbf_q ? sh_q[WORD_W-1] : sh_q[0]) : 1'b1;
  assign st_done = (st_q == ST_OK);
  assign st_err  = (st_q == ST_FAIL);
  assign busy    = (st_q == ST_PROG) || (st_q == ST_WINIT) || run;

endmodule

// File: rtl/ps_cfg_streamer.sv
module ps_cfg_streamer
  import pscs_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYC    = 8,
  parameter int INIT_TMO    = 4096,
  parameter int TRAIL_MAX   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_msbf,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cmd_srst,
  input  logic             cmd_start,
  input  logic             fifo_we,
  input  logic [1:0]       fifo_size,
  input  logic             fifo_last,
  input  logic [31:0]      fifo_data,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             prog_b_o,
  input  logic             init_b_i,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             done_i,
  output logic             stat_done,
  output logic             stat_error,
  output logic             stat_busy
);

  localparam int ENT_W = $bits(entry_t);

  logic [DIV_W-1:0] div_q, div_d;
  logic             msbf_q, msbf_d;
  logic             start_p;
  logic             init_s, done_s;
  logic             fifo_pop, tick, run, hold;
  entry_t           wr_ent, rd_ent;
  logic [ENT_W-1:0] rd_raw;

  // Control fields: next-state and register processes.
  always_comb begin
    div_d  = div_q;
    msbf_d = msbf_q;
    if (cfg_we) begin
      div_d  = cfg_div;
      msbf_d = cfg_msbf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(1);
      msbf_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      msbf_q <= msbf_d;
    end
  end

  assign start_p = cmd_start && !cmd_srst;

  assign wr_ent.last = fifo_last;
  assign wr_ent.size = fifo_size;
  assign wr_ent.data = fifo_data;
  assign rd_ent      = entry_t'(rd_raw);

  pscs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_init (
    .clk(clk), .rst_n(rst_n), .d(init_b_i), .q(init_s)
  );

  pscs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_done (
    .clk(clk), .rst_n(rst_n), .d(done_i), .q(done_s)
  );

  pscs_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (cmd_srst),
    .wr    (fifo_we),
    .wdata (wr_ent),
    .rd    (fifo_pop),
    .rdata (rd_raw),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  pscs_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .hold  (hold),
    .div   (div_q),
    .tick  (tick)
  );

  pscs_engine #(
    .PROG_CYC  (PROG_CYC),
    .INIT_TMO  (INIT_TMO),
    .TRAIL_MAX (TRAIL_MAX)
  ) i_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (cmd_srst),
    .start      (start_p),
    .msbf       (msbf_d),
    .tick       (tick),
    .init_s     (init_s),
    .done_s     (done_s),
    .fifo_empty (fifo_empty),
    .entry      (rd_ent),
    .pop        (fifo_pop),
    .run        (run),
    .hold       (hold),
    .prog_b     (prog_b_o),
    .cclk       (cclk_o),
    .din        (din_o),
    .st_done    (stat_done),
    .st_err     (stat_error),
    .busy       (stat_busy)
  );

endmodule

// File: rtl/pscs_chk.sv
module pscs_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_full,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic prog_b_o,
  input logic cclk_o,
  input logic din_o,
  input logic stat_done,
  input logic stat_error
);

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  p_no_clk_in_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_b_o |-> !cclk_o);

  p_din_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |-> $stable(din_o));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done |-> !cclk_o);

  p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_done && stat_error));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_error |-> !cclk_o);

endmodule

bind ps_cfg_streamer pscs_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .prog_b_o   (prog_b_o),
  .cclk_o     (cclk_o),
  .din_o      (din_o),
  .stat_done  (stat_done),
  .stat_error (stat_error)
);

// File: tb/test_ps_cfg_streamer.sv
module test_ps_cfg_streamer;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int DIV_W      = 8;
  localparam int PROG_CYC   = 8;
  localparam int INIT_TMO   = 200;
  localparam int TRAIL_MAX  = 16;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_msbf = 1, cmd_srst = 0, cmd_start = 0;
  logic [DIV_W-1:0] cfg_div = 1;
  logic fifo_we = 0, fifo_last = 0;
  logic [1:0] fifo_size = 0;
  logic [31:0] fifo_data = 0;
  logic fifo_full, fifo_empty, prog_b_o, cclk_o, din_o;
  logic stat_done, stat_error, stat_busy;
  logic init_drv = 1'b1;
  logic done_i = 1'b0;

  int tests = 0;
  int fails = 0;

  // target model state
  int   cyc = 0;
  logic cclk_prev = 1'b0;
  int   rx_n = 0;
  logic rx_bits [0:4095];
  int   rx_per  [0:4095];
  int   last_rise = 0;
  int   prog_low_cnt = 0;
  int   init_dly = 0;
  logic tgt_hold = 1'b0;
  logic tgt_fault = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_streamer #(
    .FIFO_DEPTH(DEPTH), .DIV_W(DIV_W), .SYNC_STAGES(2),
    .PROG_CYC(PROG_CYC), .INIT_TMO(INIT_TMO), .TRAIL_MAX(TRAIL_MAX)
  ) i_ps_cfg_streamer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_msbf(cfg_msbf),
    .cfg_div(cfg_div), .cmd_srst(cmd_srst), .cmd_start(cmd_start),
    .fifo_we(fifo_we), .fifo_size(fifo_size), .fifo_last(fifo_last),
    .fifo_data(fifo_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .prog_b_o(prog_b_o), .init_b_i(init_drv), .cclk_o(cclk_o),
    .din_o(din_o), .done_i(done_i), .stat_done(stat_done),
    .stat_error(stat_error), .stat_busy(stat_busy)
  );

  // Target model, sampled away from the active edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cclk_o && !cclk_prev && rx_n < 4096) begin
      rx_bits[rx_n] = din_o;
      rx_per[rx_n]  = cyc - last_rise;
      last_rise     = cyc;
      rx_n          = rx_n + 1;
    end
    cclk_prev = cclk_o;
    if (!prog_b_o) prog_low_cnt = prog_low_cnt + 1;
    if (!prog_b_o) begin
      init_drv = 1'b0;
      init_dly = 0;
    end else if (tgt_fault) begin
      init_drv = 1'b0;
    end else if (!init_drv && !tgt_hold) begin
      init_dly = init_dly + 1;
      if (init_dly >= 5) init_drv = 1'b1;
    end
    if (cyc == WDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic msbf, input int div);
    @(negedge clk);
    cfg_we = 1; cfg_msbf = msbf; cfg_div = DIV_W'(div);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_srst();
    @(negedge clk);
    cmd_srst = 1;
    @(negedge clk);
    cmd_srst = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic push(input logic [1:0] sz, input logic lst, input logic [31:0] d);
    @(negedge clk);
    fifo_we = 1; fifo_size = sz; fifo_last = lst; fifo_data = d;
    @(negedge clk);
    fifo_we = 0;
  endtask

  task automatic wait_rx(input int n, input int lim);
    int k = 0;
    while (rx_n < n && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wait_done(input int lim);
    int k = 0;
    while (!stat_done && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wait_err(input int lim);
    int k = 0;
    while (!stat_error && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic prep();
    pulse_srst();
    done_i = 0; tgt_hold = 0; tgt_fault = 0;
    cyc_wait(2);
    rx_n = 0; prog_low_cnt = 0;
  endtask

  function automatic logic exp_bit(input logic msbf, input logic [1:0] sz,
                                   input logic [31:0] d, input int k);
    int nb;
    nb = 8 * (int'(sz) + 1);
    return msbf ? d[nb-1-k] : d[k];
  endfunction

  task automatic chk_bits(input string req, input int base, input logic msbf,
                          input logic [1:0] sz, input logic [31:0] d);
    int mism = 0;
    for (int k = 0; k < 8 * (int'(sz) + 1); k++) begin
      if (rx_bits[base+k] !== exp_bit(msbf, sz, d, k)) mism++;
    end
    chk(req, mism, 0);
  endtask

  task automatic chk_per(input string req, input int base, input int n, input int exp);
    int bad = 0;
    for (int k = base + 1; k < base + n; k++) begin
      if (rx_per[k] != exp) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic finish_ok(input string req, input int nbits);
    int snap;
    wait_rx(nbits + 3, 500);
    chk({req, " trailing din high"}, int'(rx_bits[nbits] & rx_bits[nbits+1]), 1);
    done_i = 1;
    wait_done(40);
    chk({req, " done status"}, int'(stat_done), 1);
    chk({req, " no error"}, int'(stat_error), 0);
    snap = rx_n;
    cyc_wait(20);
    chk({req, " clock stopped after done"}, rx_n - snap, 0);
  endtask

  task automatic t_reset();
    chk("R1 prog_b high", int'(prog_b_o), 1);
    chk("R1 cclk low", int'(cclk_o), 0);
    chk("R1 done low", int'(stat_done), 0);
    chk("R1 error low", int'(stat_error), 0);
    chk("R1 busy low", int'(stat_busy), 0);
    chk("R1 fifo empty", int'(fifo_empty), 1);
    chk("R1 fifo not full", int'(fifo_full), 0);
  endtask

  // Default divider and bit order, never written.
  task automatic t_default_msbf();
    rx_n = 0; prog_low_cnt = 0;
    push(2'd3, 1'b1, 32'hA5C3_0F81);
    pulse_start();
    wait_rx(32, 2000);
    chk("R4 prog low at least PROG_CYC", int'(prog_low_cnt >= PROG_CYC), 1);
    chk("R3 default period 4", rx_per[1], 4);
    chk_per("R3 default period", 0, 8, 4);
    chk_bits("R5 msb-first word", 0, 1'b1, 2'd3, 32'hA5C3_0F81);
    finish_ok("R8", 32);
  endtask

  task automatic t_lsbf();
    prep();
    cfg_write(1'b0, 2);
    push(2'd3, 1'b0, 32'h1234_5678);
    push(2'd1, 1'b1, 32'hFFFF_9C3A);
    pulse_start();
    wait_rx(48, 3000);
    chk_per("R3 div 2 period 6", 0, 8, 6);
    chk_bits("R6 lsb-first word", 0, 1'b0, 2'd3, 32'h1234_5678);
    chk_bits("R7 two-byte entry lsb-first", 32, 1'b0, 2'd1, 32'hFFFF_9C3A);
    finish_ok("R8 lsb run", 48);
  endtask

  task automatic t_byte_msbf();
    prep();
    cfg_write(1'b1, 0);
    push(2'd0, 1'b1, 32'hFFFF_FF5A);
    pulse_start();
    wait_rx(8, 2000);
    chk_per("R3 div 0 period 2", 0, 8, 2);
    chk_bits("R7 single-byte entry msb-first", 0, 1'b1, 2'd0, 32'hFFFF_FF5A);
    finish_ok("R8 byte run", 8);
  endtask

  task automatic t_fifo();
    logic [7:0] vals [4];
    vals[0] = 8'h11; vals[1] = 8'h22; vals[2] = 8'h3C; vals[3] = 8'h96;
    prep();
    chk("R2 empty after srst", int'(fifo_empty), 1);
    for (int i = 0; i < DEPTH; i++) push(2'd0, 1'b0, {24'h0, vals[i]});
    chk("R2 full flag", int'(fifo_full), 1);
    chk("R2 not empty when full", int'(fifo_empty), 0);
    push(2'd0, 1'b1, 32'h0000_00E7);
    chk("R2 still full after dropped push", int'(fifo_full), 1);
    pulse_start();
    wait_rx(32, 2000);
    cyc_wait(30);
    chk("R13 clock halts on empty queue", rx_n, 32);
    chk("R2 dropped push not queued", int'(fifo_empty), 1);
    for (int i = 0; i < DEPTH; i++)
      chk_bits("R2 queued byte order", 8 * i, 1'b1, 2'd0, {24'h0, vals[i]});
    push(2'd0, 1'b1, 32'h0000_005A);
    wait_rx(40, 500);
    chk("R13 clock resumes after push", int'(rx_n >= 40), 1);
    chk_bits("R2 next byte after dropped push", 32, 1'b1, 2'd0, 32'h0000_005A);
    finish_ok("R13 resumed run", 40);
  endtask

  task automatic t_init_hold();
    prep();
    push(2'd3, 1'b1, 32'hC001_D00D);
    tgt_hold = 1;
    pulse_start();
    cyc_wait(60);
    chk("R4 no clock while init low", rx_n, 0);
    chk("R4 busy during handshake", int'(stat_busy), 1);
    chk("R4 no error yet", int'(stat_error), 0);
    tgt_hold = 0;
    wait_rx(32, 2000);
    chk_bits("R4 data after init release", 0, 1'b1, 2'd3, 32'hC001_D00D);
    finish_ok("R4 run", 32);
  endtask

  task automatic t_trail_tmo();
    int snap;
    prep();
    push(2'd3, 1'b1, 32'h0F0F_00FF);
    pulse_start();
    wait_err(3000);
    chk("R9 error on missing done", int'(stat_error), 1);
    chk("R9 done stays low", int'(stat_done), 0);
    chk("R9 trailing edge count", rx_n - 32, TRAIL_MAX);
    snap = rx_n;
    cyc_wait(20);
    chk("R9 clock stopped", rx_n - snap, 0);
  endtask

  task automatic t_init_fault();
    int snap;
    prep();
    push(2'd3, 1'b0, 32'h1111_2222);
    push(2'd3, 1'b1, 32'h3333_4444);
    pulse_start();
    wait_rx(10, 2000);
    tgt_fault = 1;
    wait_err(20);
    chk("R10 error on init low", int'(stat_error), 1);
    snap = rx_n;
    cyc_wait(20);
    chk("R10 clock stopped", rx_n - snap, 0);
    chk("R10 below word count", int'(rx_n < 32), 1);
    tgt_fault = 0;
  endtask

  task automatic t_restart();
    prog_low_cnt = 0;
    pulse_start();
    cyc_wait(20);
    chk("R11 start ignored when not idle", prog_low_cnt, 0);
    chk("R11 error kept", int'(stat_error), 1);
    pulse_srst();
    cyc_wait(2);
    chk("R11 error cleared", int'(stat_error), 0);
    chk("R11 done cleared", int'(stat_done), 0);
    chk("R11 queue emptied", int'(fifo_empty), 1);
    chk("R11 idle", int'(stat_busy), 0);
  endtask

  task automatic t_init_tmo();
    prep();
    push(2'd3, 1'b1, 32'hDEAD_0001);
    tgt_hold = 1;
    pulse_start();
    wait_err(400);
    chk("R12 error on init timeout", int'(stat_error), 1);
    chk("R12 no clock sent", rx_n, 0);
    tgt_hold = 0;
    pulse_srst();
  endtask

  initial begin
    cyc_wait(3);
    rst_n = 1'b1;
    cyc_wait(2);
    t_reset();
    t_default_msbf();
    t_lsbf();
    t_byte_msbf();
    t_fifo();
    t_init_hold();
    t_trail_tmo();
    t_init_fault();
    t_restart();
    t_init_tmo();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule